// File: doc/BRIEF.md
# IDE Data-Port Command Timing Sequencer

This block produces the read and write command strobes for the 16-bit data port of an IDE drive interface. It runs from the CPU local-bus clock. An upstream decoder presents a data-port access as a one-clock request, together with the direction and the target drive number (0 to 7). The request is raised in the clock that ends the first T2 bus phase. The sequencer then runs through four phases: an optional wait for the second T2, an address setup period, the command strobe, and a recovery period. It latches read data and pulses a done flag when the strobe ends. While no ISA cycle is running and the CPU owns the bus, the chip selects rest in their data-port state. This gives the address lines time to settle before a strobe.

Timing comes from two register sets, A and B. Each set holds a read length, a write length, a recovery count and an address setup count. A per-drive bit chooses which set a drive uses. Two settings are global and apply to all drives: the start point (end of first or second T2) and the write-data hold (1 or 2 clocks). An asynchronous ready input passes through a two-flop synchroniser and can stretch the strobe. Each of drives 0 to 3 can be flagged to bypass this sequencer so that its accesses go to the ISA cycle path instead.

Top module: `ide_cmd_seq`

## Requirements
- R1: While reset is held, both strobes are high (inactive), and busy, done and wd_oe are low. cs_n resets to 2'b11.
- R2: One clock after the condition changes, cs_n is 2'b10 when the sequencer is busy, or when isa_active is low and bus_ours is high. Otherwise cs_n is 2'b11. Bit 0 is the data-port select, active low.
- R3: With start_late low, a request accepted at a clock edge is followed by S clocks of busy with no strobe, where S = setup code + 1 (codes 0..3 give 1..4 clocks). The strobe then asserts.
- R4: With start_late high, the sequencer waits after acceptance with no strobe until t2_mark is seen high at a clock edge. The S setup clocks follow that edge.
- R5: For a read, rd_n stays low for read-length code + 1 clocks (codes 0..15 give 1..16).
- R6: For a write, wr_n stays low for a number of clocks set by the write-length code. Codes 0..7 give 1..8 clocks. Codes 8..15 give 10, 12, ..., 24 clocks, which is twice the code minus 6.
- R7: Drive n uses timing set B when set_b[n] is 1 and timing set A when it is 0.
- R8: When the strobe would end, the sequencer checks the synchronised ready input. If it is low, the strobe stays low and ends at the third clock edge after rdy_async rises (two synchroniser stages plus one).
- R9: At the edge where a read strobe ends, rd_data captures rd_data_in. done is high for exactly the one clock that follows a strobe.
- R10: For a write, wd_oe is high from acceptance through the strobe and for H clocks after it, with H = 2 if hold2 is set and 1 otherwise.
- R11: After the strobe, busy stays high for max(recovery code + 1, H) clocks, with H = 0 for reads. Requests that arrive while busy are dropped.
- R12: A request to a drive 0..3 whose isa_drv bit is set is ignored: no busy, no strobe, no done. Drives 4..7 always use the sequencer.
- R13: The two strobes are never low at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local-bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| acc_req | input | 1 | One-clock data-port access request, raised at the end of the first T2 |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_drive | input | 3 | Target drive number |
| t2_mark | input | 1 | Pulses in the clock that ends a T2 phase |
| isa_active | input | 1 | An ISA bus cycle is in progress |
| bus_ours | input | 1 | The CPU or local master owns the bus |
| start_late | input | 1 | Global: 0 = start after first T2, 1 = after second T2 |
| hold2 | input | 1 | Global: write data hold, 0 = 1 clock, 1 = 2 clocks |
| set_b | input | 8 | Per-drive timing set select, 1 = set B |
| isa_drv | input | 4 | Per-drive bypass flags for drives 0..3 |
| rdlen_a | input | 4 | Set A read length code |
| rdlen_b | input | 4 | Set B read length code |
| wrlen_a | input | 4 | Set A write length code |
| wrlen_b | input | 4 | Set B write length code |
| rec_a | input | 4 | Set A recovery code |
| rec_b | input | 4 | Set B recovery code |
| setup_a | input | 2 | Set A address setup code |
| setup_b | input | 2 | Set B address setup code |
| rdy_async | input | 1 | Asynchronous drive ready |
| rd_data_in | input | 16 | Read data from the drive |
| cs_n | output | 2 | Chip selects, active low; bit 0 selects the data port |
| rd_n | output | 1 | Read command strobe, active low |
| wr_n | output | 1 | Write command strobe, active low |
| wd_oe | output | 1 | Write data output enable |
| rd_data | output | 16 | Captured read data |
| done | output | 1 | One-clock pulse after a strobe ends |
| busy | output | 1 | An access is in progress |

## Verification
The assertions assume that a request arrives only as a one-clock pulse and that the configuration inputs do not change while busy is high. The bench therefore changes settings only while the sequencer is idle and drops acc_req after one clock. The checker also assumes that rdy_async eventually rises, so that every strobe ends. The bench raises ready at a chosen clock inside the strobe, and never during reset.

// File: rtl/ide_cmd_pkg.sv
package ide_cmd_pkg;

    localparam int CNT_W  = 5;
    localparam int CODE_W = 4;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT,
        ST_SETUP,
        ST_CMD,
        ST_REC
    } seq_state_t;

    typedef struct packed {
        logic [CNT_W-1:0] setup;
        logic [CNT_W-1:0] len;
        logic [CNT_W-1:0] rec;
    } tmg_t;

    function automatic logic [CNT_W-1:0] lin_decode(input logic [CODE_W-1:0] c);
        return CNT_W'(c) + CNT_W'(1);
    endfunction

    function automatic logic [CNT_W-1:0] wr_decode(input logic [CODE_W-1:0] c);
        if (!c[CODE_W-1])
            return CNT_W'(c) + CNT_W'(1);
        else
            return CNT_W'({c, 1'b0}) - CNT_W'(6);
    endfunction

endpackage

// File: rtl/ide_tmg_sel.sv
module ide_tmg_sel
    import ide_cmd_pkg::*;
#(
    parameter int NDRV  = 8,
    parameter int NISA  = 4,
    parameter int SU_W  = 2,
    localparam int DRV_W = $clog2(NDRV)
) (
    input  logic [DRV_W-1:0]  drv,
    input  logic              is_write,
    input  logic [NDRV-1:0]   set_b,
    input  logic [NISA-1:0]   isa_drv,
    input  logic [CODE_W-1:0] rdlen_a,
    input  logic [CODE_W-1:0] rdlen_b,
    input  logic [CODE_W-1:0] wrlen_a,
    input  logic [CODE_W-1:0] wrlen_b,
    input  logic [CODE_W-1:0] rec_a,
    input  logic [CODE_W-1:0] rec_b,
    input  logic [SU_W-1:0]   setup_a,
    input  logic [SU_W-1:0]   setup_b,
    output tmg_t              tmg,
    output logic              bypass
);

    logic [NDRV-1:0] byp_vec;

    for (genvar i = 0; i < NDRV; i++) begin : g_byp
        if (i < NISA) begin : g_flag
            assign byp_vec[i] = isa_drv[i];
        end else begin : g_fast
            assign byp_vec[i] = 1'b0;
        end
    end

    always_comb begin
        bypass = byp_vec[drv];
        if (set_b[drv]) begin
            tmg.setup = CNT_W'(setup_b) + CNT_W'(1);
            tmg.len   = is_write ? wr_decode(wrlen_b) : lin_decode(rdlen_b);
            tmg.rec   = lin_decode(rec_b);
        end else begin
            tmg.setup = CNT_W'(setup_a) + CNT_W'(1);
            tmg.len   = is_write ? wr_decode(wrlen_a) : lin_decode(rdlen_a);
            tmg.rec   = lin_decode(rec_a);
        end
    end

endmodule

// File: rtl/ide_rdy_sync.sv
module ide_rdy_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [STAGES-1:0] sh_d, sh_q;

    always_comb begin
        sh_d = {sh_q[STAGES-2:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign dout = sh_q[STAGES-1];

endmodule

// File: rtl/ide_cmd_fsm.sv
module ide_cmd_fsm
    import ide_cmd_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_go,
    input  logic              acc_write,
    input  tmg_t              tmg,
    input  logic              start_late,
    input  logic              hold2,
    input  logic              t2_mark,
    input  logic              rdy_s,
    input  logic              isa_active,
    input  logic              bus_ours,
    input  logic [DATA_W-1:0] rd_data_in,
    output logic [1:0]        cs_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              wd_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              busy
);

    typedef struct packed {
        seq_state_t        state;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        hold;
        logic              wr;
        tmg_t              tm;
        logic              done;
        logic [1:0]        cs_n;
        logic [DATA_W-1:0] rdata;
    } regs_t;

    regs_t r_d, r_q;

    logic [1:0]       hold_len;
    logic [CNT_W-1:0] post_len;

    always_comb begin
        hold_len = r_q.wr ? (hold2 ? 2'd2 : 2'd1) : 2'd0;
        post_len = (r_q.tm.rec > CNT_W'(hold_len)) ? r_q.tm.rec : CNT_W'(hold_len);

        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.state)
            ST_IDLE: begin
                if (acc_go) begin
                    r_d.wr = acc_write;
                    r_d.tm = tmg;
                    if (start_late) begin
                        r_d.state = ST_WAIT;
                    end else begin
                        r_d.state = ST_SETUP;
                        r_d.cnt   = tmg.setup;
                    end
                end
            end
            ST_WAIT: begin
                if (t2_mark) begin
                    r_d.state = ST_SETUP;
                    r_d.cnt   = r_q.tm.setup;
                end
            end
            ST_SETUP: begin
                if (r_q.cnt == CNT_W'(1)) begin
                    r_d.state = ST_CMD;
                    r_d.cnt   = r_q.tm.len;
                end else begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end
            end
            ST_CMD: begin
                if (r_q.cnt != CNT_W'(1)) begin
                    r_d.cnt = r_q.cnt - CNT_W'(1);
                end else if (rdy_s) begin
                    r_d.state = ST_REC;
                    r_d.cnt   = post_len;
                    r_d.hold  = hold_len;
                    r_d.done  = 1'b1;
                    if (!r_q.wr) r_d.rdata = rd_data_in;
                end
            end
            ST_REC: begin
                if (r_q.hold != 2'd0) r_d.hold = r_q.hold - 2'd1;
                if (r_q.cnt == CNT_W'(1)) r_d.state = ST_IDLE;
                else                      r_d.cnt   = r_q.cnt - CNT_W'(1);
            end
            default: r_d.state = ST_IDLE;
        endcase

        r_d.cs_n = ((r_d.state != ST_IDLE) || (!isa_active && bus_ours)) ? 2'b10 : 2'b11;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.cs_n  <= 2'b11;
        end else begin
            r_q <= r_d;
        end
    end

    assign cs_n    = r_q.cs_n;
    assign rd_n    = !((r_q.state == ST_CMD) && !r_q.wr);
    assign wr_n    = !((r_q.state == ST_CMD) && r_q.wr);
    assign wd_oe   = r_q.wr && ((r_q.state == ST_WAIT) || (r_q.state == ST_SETUP) ||
                                (r_q.state == ST_CMD)  ||
                                ((r_q.state == ST_REC) && (r_q.hold != 2'd0)));
    assign busy    = (r_q.state != ST_IDLE);
    assign done    = r_q.done;
    assign rd_data = r_q.rdata;

endmodule

// File: rtl/ide_cmd_seq.sv
module ide_cmd_seq
    import ide_cmd_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int NDRV     = 8,
    parameter int NISA     = 4,
    parameter int SU_W     = 2,
    parameter int SYNC_STG = 2,
    localparam int DRV_W   = $clog2(NDRV)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic              acc_write,
    input  logic [DRV_W-1:0]  acc_drive,
    input  logic              t2_mark,
    input  logic              isa_active,
    input  logic              bus_ours,
    input  logic              start_late,
    input  logic              hold2,
    input  logic [NDRV-1:0]   set_b,
    input  logic [NISA-1:0]   isa_drv,
    input  logic [3:0]        rdlen_a,
    input  logic [3:0]        rdlen_b,
    input  logic [3:0]        wrlen_a,
    input  logic [3:0]        wrlen_b,
    input  logic [3:0]        rec_a,
    input  logic [3:0]        rec_b,
    input  logic [SU_W-1:0]   setup_a,
    input  logic [SU_W-1:0]   setup_b,
    input  logic              rdy_async,
    input  logic [DATA_W-1:0] rd_data_in,
    output logic [1:0]        cs_n,
    output logic              rd_n,
    output logic              wr_n,
    output logic              wd_oe,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              busy
);

    tmg_t tmg;
    logic bypass;
    logic rdy_s;

    ide_tmg_sel #(.NDRV(NDRV), .NISA(NISA), .SU_W(SU_W)) u_sel (
        .drv      (acc_drive),
        .is_write (acc_write),
        .set_b    (set_b),
        .isa_drv  (isa_drv),
        .rdlen_a  (rdlen_a),
        .rdlen_b  (rdlen_b),
        .wrlen_a  (wrlen_a),
        .wrlen_b  (wrlen_b),
        .rec_a    (rec_a),
        .rec_b    (rec_b),
        .setup_a  (setup_a),
        .setup_b  (setup_b),
        .tmg      (tmg),
        .bypass   (bypass)
    );

    ide_rdy_sync #(.STAGES(SYNC_STG)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .din  (rdy_async),
        .dout (rdy_s)
    );

    ide_cmd_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .acc_go     (acc_req && !bypass),
        .acc_write  (acc_write),
        .tmg        (tmg),
        .start_late (start_late),
        .hold2      (hold2),
        .t2_mark    (t2_mark),
        .rdy_s      (rdy_s),
        .isa_active (isa_active),
        .bus_ours   (bus_ours),
        .rd_data_in (rd_data_in),
        .cs_n       (cs_n),
        .rd_n       (rd_n),
        .wr_n       (wr_n),
        .wd_oe      (wd_oe),
        .rd_data    (rd_data),
        .done       (done),
        .busy       (busy)
    );

endmodule

// File: rtl/ide_cmd_seq_chk.sv
module ide_cmd_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic rd_n,
    input logic wr_n,
    input logic wd_oe,
    input logic done,
    input logic busy
);

    assert_one_strobe_R13: assert property (@(posedge clk) disable iff (!rst_n)
        !(!rd_n && !wr_n));

    assert_done_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_done_at_end_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> ($rose(rd_n) || $rose(wr_n)));

    assert_setup_first_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(rd_n) || $fell(wr_n)) |-> $past(busy));

    assert_strobe_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n || !wr_n) |-> busy);

    assert_wdoe_cover_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_n |-> wd_oe);

    assert_wdoe_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wr_n) |-> wd_oe);

endmodule

bind ide_cmd_seq ide_cmd_seq_chk u_chk (
    .clk  (clk),
    .rst_n(rst_n),
    .rd_n (rd_n),
    .wr_n (wr_n),
    .wd_oe(wd_oe),
    .done (done),
    .busy (busy)
);

// File: tb/ide_cmd_seq_test.sv
`timescale 1ns/1ps
module ide_cmd_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        acc_req = 1'b0, acc_write = 1'b0;
    logic [2:0]  acc_drive = '0;
    logic        t2_mark = 1'b0, isa_active = 1'b0, bus_ours = 1'b1;
    logic        start_late = 1'b0, hold2 = 1'b0;
    logic [7:0]  set_b = '0;
    logic [3:0]  isa_drv = '0;
    logic [3:0]  rdlen_a = '0, rdlen_b = '0, wrlen_a = '0, wrlen_b = '0, rec_a = '0, rec_b = '0;
    logic [1:0]  setup_a = '0, setup_b = '0;
    logic        rdy_async = 1'b1;
    logic [15:0] rd_data_in = '0;
    logic [1:0]  cs_n;
    logic        rd_n, wr_n, wd_oe, done, busy;
    logic [15:0] rd_data;

    int vectors = 0;
    int fails = 0;

    always #10 clk = ~clk;

    ide_cmd_seq uut (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_write(acc_write),
        .acc_drive(acc_drive), .t2_mark(t2_mark), .isa_active(isa_active),
        .bus_ours(bus_ours), .start_late(start_late), .hold2(hold2),
        .set_b(set_b), .isa_drv(isa_drv), .rdlen_a(rdlen_a), .rdlen_b(rdlen_b),
        .wrlen_a(wrlen_a), .wrlen_b(wrlen_b), .rec_a(rec_a), .rec_b(rec_b),
        .setup_a(setup_a), .setup_b(setup_b), .rdy_async(rdy_async),
        .rd_data_in(rd_data_in), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .wd_oe(wd_oe), .rd_data(rd_data), .done(done), .busy(busy)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic pulse_req(input bit wr, input int drv);
        @(negedge clk);
        acc_req = 1'b1; acc_write = wr; acc_drive = 3'(drv);
        @(negedge clk);
        acc_req = 1'b0;
    endtask

    // Measures one access from the negedge after acceptance.
    task automatic measure(input bit wr, input int es, input int el, input int ep,
                           input int eh, input logic [15:0] ed, input string tag);
        int s = 0, l = 0, p = 0, h = 0, extra = 0;
        bit dn;
        while (busy && rd_n && wr_n && s < 100) begin s++; @(negedge clk); end
        while ((!rd_n || !wr_n) && l < 100) begin l++; @(negedge clk); end
        dn = done;
        if (!wr) chk(rd_data == ed, {tag, " R9 read data"}, int'(rd_data), int'(ed));
        while (busy && p < 100) begin
            p++;
            if (wd_oe) h++;
            if (p > 1 && done) extra++;
            @(negedge clk);
        end
        chk(s == es, {tag, " R3 setup clocks"}, s, es);
        chk(l == el, {tag, " strobe clocks R5/R6"}, l, el);
        chk(dn == 1'b1 && extra == 0, {tag, " R9 done pulse"}, int'(dn), 1);
        chk(p == ep, {tag, " R11 recovery busy"}, p, ep);
        chk(h == eh, {tag, " R10 data hold"}, h, eh);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk(rd_n && wr_n && !busy && !done && !wd_oe && cs_n == 2'b11,
            "R1 reset state", int'({rd_n, wr_n, busy, done, wd_oe, cs_n}), 7'b1100011);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic t_cs;
        chk(cs_n == 2'b10, "R2 default select", int'(cs_n), 2);
        isa_active = 1'b1;
        @(negedge clk);
        chk(cs_n == 2'b11, "R2 isa active", int'(cs_n), 3);
        isa_active = 1'b0; bus_ours = 1'b0;
        @(negedge clk);
        chk(cs_n == 2'b11, "R2 bus not ours", int'(cs_n), 3);
        pulse_req(1'b0, 1);
        chk(cs_n == 2'b10, "R2 busy forces select", int'(cs_n), 2);
        while (busy) @(negedge clk);
        bus_ours = 1'b1;
        @(negedge clk);
        chk(cs_n == 2'b10, "R2 select restored", int'(cs_n), 2);
    endtask

    task automatic t_read;
        setup_a = 2'd2; rdlen_a = 4'd4; rec_a = 4'd3; rd_data_in = 16'hA5C3;
        pulse_req(1'b0, 1);
        measure(1'b0, 3, 5, 4, 0, 16'hA5C3, "read A");
        rd_data_in = 16'h0F0F;
        repeat (2) @(negedge clk);
        chk(rd_data == 16'hA5C3, "R9 data held", int'(rd_data), 16'hA5C3);
    endtask

    task automatic t_write;
        setup_a = 2'd0; rec_a = 4'd0;
        wrlen_a = 4'd0;  hold2 = 1'b0; pulse_req(1'b1, 0); measure(1'b1, 1, 1, 1, 1, 16'h0, "R6 wr code0");
        wrlen_a = 4'd7;  pulse_req(1'b1, 0); measure(1'b1, 1, 8, 1, 1, 16'h0, "R6 wr code7");
        wrlen_a = 4'd8;  hold2 = 1'b1; pulse_req(1'b1, 0); measure(1'b1, 1, 10, 2, 2, 16'h0, "R6 wr code8");
        wrlen_a = 4'd15; hold2 = 1'b0; setup_a = 2'd3;
        pulse_req(1'b1, 0); measure(1'b1, 4, 24, 1, 1, 16'h0, "R6 wr code15");
    endtask

    task automatic t_setb;
        set_b = 8'b0010_0000;
        setup_a = 2'd3; rdlen_a = 4'd9; rec_a = 4'd2;
        setup_b = 2'd0; rdlen_b = 4'd0; rec_b = 4'd15;
        rd_data_in = 16'h1234;
        pulse_req(1'b0, 5); measure(1'b0, 1, 1, 16, 0, 16'h1234, "R7 drive5 set B");
        rd_data_in = 16'h4321;
        pulse_req(1'b0, 4); measure(1'b0, 4, 10, 3, 0, 16'h4321, "R7 drive4 set A");
        set_b = '0;
    endtask

    task automatic t_ready;
        int l = 0;
        setup_a = 2'd0; rdlen_a = 4'd1; rec_a = 4'd0;
        rdy_async = 1'b0;
        repeat (3) @(negedge clk);
        pulse_req(1'b0, 2);
        while (busy && rd_n) @(negedge clk);
        while (!rd_n && l < 100) begin
            l++;
            if (l == 6) rdy_async = 1'b1;
            @(negedge clk);
        end
        chk(l == 8, "R8 ready stretch", l, 8);
        while (busy) @(negedge clk);
        rdlen_a = 4'd7; rdy_async = 1'b0; l = 0;
        repeat (3) @(negedge clk);
        pulse_req(1'b0, 2);
        while (busy && rd_n) @(negedge clk);
        while (!rd_n && l < 100) begin
            l++;
            if (l == 1) rdy_async = 1'b1;
            @(negedge clk);
        end
        chk(l == 8, "R8 early ready no stretch", l, 8);
        while (busy) @(negedge clk);
    endtask

    task automatic t_late;
        int lows = 0;
        start_late = 1'b1; setup_a = 2'd1; rdlen_a = 4'd2; rec_a = 4'd0;
        rd_data_in = 16'hBEEF;
        pulse_req(1'b0, 3);
        for (int i = 0; i < 6; i++) begin
            if (!rd_n || !busy) lows++;
            @(negedge clk);
        end
        chk(lows == 0, "R4 waits for second T2", lows, 0);
        t2_mark = 1'b1;
        @(negedge clk);
        t2_mark = 1'b0;
        measure(1'b0, 2, 3, 1, 0, 16'hBEEF, "R4 late start");
        start_late = 1'b0;
    endtask

    task automatic t_busy_drop;
        int lows = 0;
        int b = 0;
        set_b = 8'b0010_0000; setup_b = 2'd0; rdlen_b = 4'd0; rec_b = 4'd7;
        pulse_req(1'b0, 5);
        while (busy && rd_n) @(negedge clk);
        while (!rd_n) @(negedge clk);
        pulse_req(1'b1, 5);
        while (busy) @(negedge clk);
        for (int i = 0; i < 10; i++) begin
            if (!rd_n || !wr_n) lows++;
            if (busy) b++;
            @(negedge clk);
        end
        chk(lows == 0 && b == 0, "R11 request while busy dropped", lows + b, 0);
        set_b = '0;
    endtask

    task automatic t_bypass;
        int b = 0;
        isa_drv = 4'b0100;
        pulse_req(1'b0, 2);
        for (int i = 0; i < 12; i++) begin
            if (busy || !rd_n || done) b++;
            @(negedge clk);
        end
        chk(b == 0, "R12 flagged drive ignored", b, 0);
        isa_drv = 4'b1111; setup_a = 2'd0; rdlen_a = 4'd0; rec_a = 4'd0;
        rd_data_in = 16'h5A5A;
        pulse_req(1'b0, 6);
        measure(1'b0, 1, 1, 1, 0, 16'h5A5A, "R12 drive6 fast path");
        isa_drv = '0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        t_reset();
        t_cs();
        t_read();
        t_write();
        t_setb();
        t_ready();
        t_late();
        t_busy_drop();
        t_bypass();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule